// File: doc/BRIEF.md
# Streaming Level and Edge Trigger Detector

This block watches a stream of 16-channel logic samples and raises a one-cycle trigger pulse when a combined condition holds. The condition has three parts, and all of them must hold on the same accepted sample. The first is a level match under a mask. The second is a rising-edge condition that compares the previous accepted sample with the current one. The third is a falling-edge condition of the same kind. A part whose mask is zero counts as satisfied.

Once the trigger has fired, a sticky status bit stays high and no further pulse is produced. An arm strobe clears the status so the next match can fire again.

A mode input selects normal or fast operation. Each mode has its own rules for which configurations are legal. A configuration that breaks the rules raises an error flag, and the trigger is held off for as long as the flag is set.

Top module: `edge_level_trigger`

## Requirements
- R1: After reset, `trig_pulse`, `triggered` and `config_error` (with all masks zero) are 0, and the stored previous sample is all zeros, so a first accepted sample with a rising-masked bit at 1 counts as a rising edge.
- R2: The level part holds when (`smp_data` AND `lvl_mask`) equals `lvl_value`. A `lvl_value` bit outside the mask therefore never matches.
- R3: The rising part holds only when every `rise_mask` bit was 0 in the previous accepted sample and is 1 in the current one.
- R4: The falling part holds only when every `fall_mask` bit was 1 in the previous accepted sample and is 0 in the current one.
- R5: A match needs the level, rising and falling parts all true on the same sample. A zero mask makes its part true.
- R6: The previous-sample register loads only when `smp_valid` is 1. A sample presented with `smp_valid` at 0 neither matches nor changes the edge reference.
- R7: A match on the sample accepted at clock edge N drives `trig_pulse` high for exactly the cycle after edge N. `triggered` rises at that same edge.
- R8: While `triggered` is 1, matches give no pulse. A cycle with `arm` at 1 clears `triggered` and gives no pulse, even if a match occurs in that cycle.
- R9: In normal mode (`fast_mode`=0), `config_error` is 1 when more than one distinct channel is set across `rise_mask` OR `fall_mask`. While the flag is 1, no pulse is produced.
- R10: In fast mode (`fast_mode`=1), `config_error` is 1 when any `lvl_mask` bit is set, or when the total count of set bits in `rise_mask` plus `fall_mask` exceeds one. This includes one pin set for both edge types.
- R11: `config_error` is combinational from the configuration inputs and follows them in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm | input | 1 | Clears the triggered status |
| fast_mode | input | 1 | 0 normal mode, 1 fast mode |
| smp_valid | input | 1 | Qualifies `smp_data` |
| smp_data | input | 16 | Current channel sample |
| lvl_value | input | 16 | Level pattern to compare against |
| lvl_mask | input | 16 | Channels taking part in the level compare |
| rise_mask | input | 16 | Channels that must rise together |
| fall_mask | input | 16 | Channels that must fall together |
| trig_pulse | output | 1 | One-cycle trigger pulse |
| triggered | output | 1 | Sticky status, set with the pulse |
| config_error | output | 1 | Illegal configuration for the chosen mode |

## Verification
The bench targets the edge reference first. It presents matching data while `smp_valid` is low, which would make a design that loads the reference on every cycle miss the later real edge. It also presents a rising bit on the very first sample, which catches a design that resets the reference to anything other than zero.

It sets a level value bit outside the mask, which a design that masks both sides would wrongly accept. It combines level and edge parts so that an OR in place of an AND fires early.

It drives arm in the same cycle as a match, which exposes a design whose set path wins over the clear. It also walks the mode rules: a pin set for both edges is legal in normal mode but illegal in fast mode, and a design that mixes up distinct-channel and total-bit counting reports the wrong flag.

// File: rtl/trig_pkg.sv
package trig_pkg;

   typedef struct packed {
      logic level_ok;
      logic rise_ok;
      logic fall_ok;
   } trig_parts_t;

   typedef enum logic {
      EDGE_RISE = 1'b0,
      EDGE_FALL = 1'b1
   } edge_kind_e;

endpackage

// File: rtl/trig_level_cmp.sv
module trig_level_cmp #(
   parameter int NCH = 16
) (
   input  logic [NCH-1:0] sample,
   input  logic [NCH-1:0] value,
   input  logic [NCH-1:0] mask,
   output logic           hit
);
   generate
      if (NCH < 1) begin : g_bad_width
         $error("trig_level_cmp: NCH must be at least 1");
      end
   endgenerate

   always_comb begin
      hit = ((sample & mask) == value);
   end
endmodule

// File: rtl/trig_edge_cmp.sv
module trig_edge_cmp
   import trig_pkg::*;
#(
   parameter int         NCH  = 16,
   parameter edge_kind_e KIND = EDGE_RISE
) (
   input  logic [NCH-1:0] prev,
   input  logic [NCH-1:0] cur,
   input  logic [NCH-1:0] mask,
   output logic           hit
);
   logic [NCH-1:0] prev_sel;
   logic [NCH-1:0] cur_sel;

   always_comb begin
      prev_sel = prev & mask;
      cur_sel  = cur & mask;
   end

   generate
      if (KIND == EDGE_RISE) begin : g_rise
         always_comb hit = (prev_sel == '0) && (cur_sel == mask);
      end else begin : g_fall
         always_comb hit = (prev_sel == mask) && (cur_sel == '0);
      end
   endgenerate
endmodule

// File: rtl/trig_cfg_check.sv
module trig_cfg_check #(
   parameter int NCH = 16
) (
   input  logic           fast_mode,
   input  logic [NCH-1:0] lvl_mask,
   input  logic [NCH-1:0] rise_mask,
   input  logic [NCH-1:0] fall_mask,
   output logic           err
);
   localparam int CW = $clog2(2 * NCH + 1);

   logic [CW-1:0] n_union;
   logic [CW-1:0] n_total;
   logic [NCH-1:0] either;

   always_comb begin
      either  = rise_mask | fall_mask;
      n_union = '0;
      n_total = '0;
      for (int i = 0; i < NCH; i++) begin
         n_union = n_union + CW'(either[i]);
         n_total = n_total + CW'(rise_mask[i]) + CW'(fall_mask[i]);
      end
      if (fast_mode)
         err = (lvl_mask != '0) || (n_total > CW'(1));
      else
         err = (n_union > CW'(1));
   end
endmodule

// File: rtl/edge_level_trigger.sv
module edge_level_trigger
   import trig_pkg::*;
#(
   parameter int NCH = 16
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           arm,
   input  logic           fast_mode,
   input  logic           smp_valid,
   input  logic [NCH-1:0] smp_data,
   input  logic [NCH-1:0] lvl_value,
   input  logic [NCH-1:0] lvl_mask,
   input  logic [NCH-1:0] rise_mask,
   input  logic [NCH-1:0] fall_mask,
   output logic           trig_pulse,
   output logic           triggered,
   output logic           config_error
);
   localparam int NEDGE = 2;

   logic [NCH-1:0] prev_q;
   trig_parts_t    parts;
   logic [NEDGE-1:0] edge_hit;
   logic           cfg_bad;
   logic           match;

   trig_level_cmp #(.NCH(NCH)) u_level (
      .sample (smp_data),
      .value  (lvl_value),
      .mask   (lvl_mask),
      .hit    (parts.level_ok)
   );

   generate
      for (genvar e = 0; e < NEDGE; e++) begin : g_edge
         localparam edge_kind_e K = (e == 0) ? EDGE_RISE : EDGE_FALL;
         trig_edge_cmp #(.NCH(NCH), .KIND(K)) u_edge (
            .prev (prev_q),
            .cur  (smp_data),
            .mask ((e == 0) ? rise_mask : fall_mask),
            .hit  (edge_hit[e])
         );
      end
   endgenerate

   always_comb begin
      parts.rise_ok = edge_hit[0];
      parts.fall_ok = edge_hit[1];
   end

   trig_cfg_check #(.NCH(NCH)) u_cfg (
      .fast_mode (fast_mode),
      .lvl_mask  (lvl_mask),
      .rise_mask (rise_mask),
      .fall_mask (fall_mask),
      .err       (cfg_bad)
   );

   always_comb begin
      match        = smp_valid && (&parts) && !cfg_bad;
      config_error = cfg_bad;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
      end else if (smp_valid) begin
         prev_q <= smp_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trig_pulse <= 1'b0;
         triggered  <= 1'b0;
      end else if (arm) begin
         trig_pulse <= 1'b0;
         triggered  <= 1'b0;
      end else if (match && !triggered) begin
         trig_pulse <= 1'b1;
         triggered  <= 1'b1;
      end else begin
         trig_pulse <= 1'b0;
      end
   end
endmodule

// File: rtl/trig_match_chk.sv
module trig_match_chk #(
   parameter int NCH = 16
) (
   input logic           clk,
   input logic           rst_n,
   input logic           arm,
   input logic           smp_valid,
   input logic           trig_pulse,
   input logic           triggered,
   input logic           config_error
);
   // R7
   pulse_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trig_pulse |-> $past(smp_valid));

   // R7
   pulse_sets_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trig_pulse |-> triggered);

   // R8
   status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (triggered && !arm) |=> triggered);

   // R8
   arm_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      arm |=> (!triggered && !trig_pulse));

   // R8
   no_repeat_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trig_pulse |-> !$past(triggered));

   // R9
   error_blocks_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trig_pulse |-> !$past(config_error));

   // R7
   single_cycle_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trig_pulse |=> !trig_pulse);
endmodule

bind edge_level_trigger trig_match_chk #(.NCH(NCH)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .arm          (arm),
   .smp_valid    (smp_valid),
   .trig_pulse   (trig_pulse),
   .triggered    (triggered),
   .config_error (config_error)
);

// File: tb/sim_edge_level_trigger.sv
module sim_edge_level_trigger;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        arm = 1'b0;
   logic        fast_mode = 1'b0;
   logic        smp_valid = 1'b0;
   logic [15:0] smp_data = '0;
   logic [15:0] lvl_value = '0;
   logic [15:0] lvl_mask = '0;
   logic [15:0] rise_mask = '0;
   logic [15:0] fall_mask = '0;
   logic        trig_pulse;
   logic        triggered;
   logic        config_error;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   edge_level_trigger #(.NCH(16)) u0 (
      .clk(clk), .rst_n(rst_n), .arm(arm), .fast_mode(fast_mode),
      .smp_valid(smp_valid), .smp_data(smp_data), .lvl_value(lvl_value),
      .lvl_mask(lvl_mask), .rise_mask(rise_mask), .fall_mask(fall_mask),
      .trig_pulse(trig_pulse), .triggered(triggered), .config_error(config_error)
   );

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
      end
   endtask

   task automatic cfg(input logic f, input logic [15:0] v, input logic [15:0] m,
                      input logic [15:0] r, input logic [15:0] fl);
      @(negedge clk);
      fast_mode = f; lvl_value = v; lvl_mask = m; rise_mask = r; fall_mask = fl;
   endtask

   task automatic do_arm();
      @(negedge clk); arm = 1'b1;
      @(negedge clk); arm = 1'b0;
   endtask

   // one accepted sample; pulse is checked in the cycle after the accepting edge
   task automatic send(input logic [15:0] d, input logic exp_p, input string req);
      @(negedge clk); smp_data = d; smp_valid = 1'b1;
      @(negedge clk); smp_valid = 1'b0;
      chk(req, "trig_pulse", trig_pulse, exp_p);
   endtask

   task automatic t_reset();
      chk("R1", "trig_pulse at reset", trig_pulse, 1'b0);
      chk("R1", "triggered at reset", triggered, 1'b0);
      chk("R1", "config_error at reset", config_error, 1'b0);
      cfg(1'b0, 16'h0000, 16'h0000, 16'h0100, 16'h0000);
      send(16'h0100, 1'b1, "R1");
      chk("R7", "triggered after pulse", triggered, 1'b1);
      @(negedge clk);
      chk("R7", "pulse one cycle wide", trig_pulse, 1'b0);
      do_arm();
   endtask

   task automatic t_rise();
      send(16'h0100, 1'b0, "R3");
      send(16'h0000, 1'b0, "R3");
      send(16'h0100, 1'b1, "R3");
      do_arm();
   endtask

   task automatic t_fall();
      cfg(1'b0, 16'h0000, 16'h0000, 16'h0000, 16'h8000);
      send(16'h8000, 1'b0, "R4");
      send(16'h8000, 1'b0, "R4");
      send(16'h0000, 1'b1, "R4");
      do_arm();
   endtask

   task automatic t_level();
      cfg(1'b0, 16'h0050, 16'h00F0, 16'h0000, 16'h0000);
      send(16'h1234, 1'b0, "R2");
      send(16'hAB5C, 1'b1, "R2");
      do_arm();
      cfg(1'b0, 16'h0010, 16'h000F, 16'h0000, 16'h0000);
      send(16'h0010, 1'b0, "R2");
      send(16'h0000, 1'b0, "R2");
   endtask

   task automatic t_combined();
      cfg(1'b0, 16'h00A0, 16'h00F0, 16'h0001, 16'h0000);
      send(16'h00A0, 1'b0, "R5");
      send(16'h00B1, 1'b0, "R5");
      send(16'h00A0, 1'b0, "R5");
      send(16'h00A1, 1'b1, "R5");
      do_arm();
   endtask

   task automatic t_valid_gate();
      cfg(1'b0, 16'h0000, 16'h0000, 16'h0001, 16'h0000);
      send(16'h0000, 1'b0, "R6");
      @(negedge clk); smp_data = 16'h0001; smp_valid = 1'b0;
      @(negedge clk);
      chk("R6", "no pulse without valid", trig_pulse, 1'b0);
      @(negedge clk);
      send(16'h0001, 1'b1, "R6");
      do_arm();
   endtask

   task automatic t_sticky();
      send(16'h0000, 1'b0, "R8");
      send(16'h0001, 1'b1, "R8");
      send(16'h0000, 1'b0, "R8");
      send(16'h0001, 1'b0, "R8");
      chk("R8", "status held", triggered, 1'b1);
      send(16'h0000, 1'b0, "R8");
      @(negedge clk); arm = 1'b1; smp_data = 16'h0001; smp_valid = 1'b1;
      @(negedge clk); arm = 1'b0; smp_valid = 1'b0;
      chk("R8", "arm beats match pulse", trig_pulse, 1'b0);
      chk("R8", "arm clears status", triggered, 1'b0);
   endtask

   task automatic t_normal_cfg();
      cfg(1'b0, 16'h0000, 16'h0000, 16'h0003, 16'h0000);
      #1 chk("R11", "two rising pins flag now", config_error, 1'b1);
      send(16'h0000, 1'b0, "R9");
      send(16'h0003, 1'b0, "R9");
      cfg(1'b0, 16'h0000, 16'h0000, 16'h0001, 16'h0002);
      #1 chk("R9", "rise+fall distinct pins", config_error, 1'b1);
      cfg(1'b0, 16'h0000, 16'h00FF, 16'h0004, 16'h0004);
      #1 chk("R9", "same pin both edges legal", config_error, 1'b0);
   endtask

   task automatic t_fast_cfg();
      cfg(1'b1, 16'h0000, 16'h0000, 16'h0010, 16'h0000);
      #1 chk("R10", "single fast edge legal", config_error, 1'b0);
      send(16'h0000, 1'b0, "R10");
      send(16'h0010, 1'b1, "R10");
      do_arm();
      cfg(1'b1, 16'h0001, 16'h0001, 16'h0010, 16'h0000);
      #1 chk("R10", "level mask in fast", config_error, 1'b1);
      cfg(1'b1, 16'h0000, 16'h0000, 16'h0010, 16'h0010);
      #1 chk("R10", "both edges one pin fast", config_error, 1'b1);
      send(16'h0000, 1'b0, "R10");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_rise();
      t_fall();
      t_level();
      t_combined();
      t_valid_gate();
      t_sticky();
      t_normal_cfg();
      t_fast_cfg();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule